// File: doc/BRIEF.md
# Pulse-Triggered Timer and Counter Snapshot Sequencer

This block turns the rising edge of a once-per-second timing pulse into a fixed, jitter-free burst of register captures. Software plays no part in the timing. The pulse first passes through a two-flop synchroniser and an edge detector. The sequencer then starts on the next clock and walks a short capture list, one entry per slot. The list reads the 64-bit microsecond timer as upper, lower, upper, lower, and then the cascaded frequency counter the same way. It ends when it reaches an empty entry.

The eight 32-bit words land in a capture buffer. A one-cycle completion strobe marks the end of the run. Each pair of split reads is also merged into a coherent 64-bit value: one for the timestamp and one for the count. The first lower-timer read is the timestamp instant. The first lower-counter read is the count instant, a fixed number of slots later. A pulse edge that arrives while a run is in progress is not acted on. It only raises a sticky overrun flag.

Top module: `pps_snapshot`

## Requirements
- R1: After reset, busy, done and overrun are low, and the eight buffer words, the merged timestamp and the merged count are all zero.
- R2: The pulse input passes through two synchroniser flops before edge detection, and the run starts on the clock after detection. If the pulse rises between clock edges P and P+1, buffer word 0 holds the timer value presented just before edge P+4.
- R3: The buffer word order is fixed: word 0 timer upper, word 1 timer lower, word 2 timer upper, word 3 timer lower, word 4 counter upper, word 5 counter lower, word 6 counter upper, word 7 counter lower.
- R4: Consecutive captures are SLOT_CYC clocks apart (default 3). The count instant (word 5) therefore trails the timestamp instant (word 1) by 4*SLOT_CYC clocks.
- R5: The run ends at the empty ninth list entry. done is high for exactly one cycle, the cycle after word 7 is captured (edge P+4+7*SLOT_CYC), and busy is low in that cycle.
- R6: A rising edge detected while busy sets overrun. The run in progress is unaffected. overrun stays set until the next accepted start clears it.
- R7: Outside a run the buffer does not change: between done and the next accepted start, all eight words hold their values.
- R8: Merged timestamp: if words 0 and 2 are equal it is {word0, word1}, otherwise {word2, word3}.
- R9: Merged count: if words 4 and 6 are equal it is {word4, word5}. Otherwise, if word5 <= word7 it is {word6, word5}, else {word4, word5}. This gives the counter value at the word-5 instant.
- R10: A pulse input held high starts exactly one run; only a low-to-high transition starts a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_i | input | 1 | Asynchronous once-per-second pulse |
| tmr_hi_i | input | 32 | Live upper word of the microsecond timer |
| tmr_lo_i | input | 32 | Live lower word of the microsecond timer |
| cnt_hi_i | input | 32 | Live slow (upper) counter stage |
| cnt_lo_i | input | 32 | Live fast (lower) counter stage |
| words_o | output | 256 | Capture buffer, word k at bits 32k+31:32k |
| stamp_o | output | 64 | Merged timestamp |
| count_o | output | 64 | Merged counter value |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion strobe |
| overrun_o | output | 1 | Sticky flag for an edge ignored while busy |

## Verification
A wrong slot counter or list index shows up at once as a buffer word that holds the wrong source, or a source sampled in the wrong cycle. Because the timer and counter are driven as ramps, every misplaced sample shows as a numeric offset in the words read when done fires, 4+7*SLOT_CYC clocks after the pulse. A stuck busy or overrun state shows as a missing or extra done strobe, or a wrong flag, in the same or the following run. A wrong merge choice shows only when the lower word wraps between paired reads, so bases near the wrap point are forced at each read position.

// File: rtl/pps_snap_pkg.sv
package pps_snap_pkg;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'd0,
        SRC_TMR_HI = 3'd1,
        SRC_TMR_LO = 3'd2,
        SRC_CNT_HI = 3'd3,
        SRC_CNT_LO = 3'd4
    } src_e;

    // Eight capture entries followed by one empty terminator
    localparam int unsigned N_CAPS   = 8;
    localparam int unsigned LIST_LEN = N_CAPS + 1;

    // Capture list computed from the entry position:
    // positions 0-3 read the timer, 4-7 the counter; even = upper, odd = lower
    function automatic src_e list_entry(input int unsigned pos);
        src_e s;
        if (pos >= N_CAPS) begin
            s = SRC_NONE;
        end else if (pos < N_CAPS / 2) begin
            s = (pos % 2 == 0) ? SRC_TMR_HI : SRC_TMR_LO;
        end else begin
            s = (pos % 2 == 0) ? SRC_CNT_HI : SRC_CNT_LO;
        end
        return s;
    endfunction

    // Fixed buffer slots that the merge logic decodes
    localparam int unsigned SLOT_TH1 = 0;
    localparam int unsigned SLOT_TL1 = 1;
    localparam int unsigned SLOT_TH2 = 2;
    localparam int unsigned SLOT_TL2 = 3;
    localparam int unsigned SLOT_CH1 = 4;
    localparam int unsigned SLOT_CL1 = 5;
    localparam int unsigned SLOT_CH2 = 6;
    localparam int unsigned SLOT_CL2 = 7;

endpackage

// File: rtl/pps_snap_sync.sv
module pps_snap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic rise_o
);
    localparam int unsigned SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pulse_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // The last synchroniser flop is high and the delayed copy is still low
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R2: a detected edge lasts one cycle
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pps_snap_seq.sv
module pps_snap_seq
    import pps_snap_pkg::*;
#(
    parameter int unsigned SLOT_CYC = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rise_i,
    output logic                         cap_en_o,
    output logic [$clog2(N_CAPS)-1:0]    cap_slot_o,
    output src_e                         cap_src_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         ovr_o
);
    localparam int unsigned IDX_W  = $clog2(LIST_LEN);
    localparam int unsigned SLOT_W = $clog2(N_CAPS);
    localparam int unsigned PH_W   = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYC - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             ovr;
        logic [IDX_W-1:0] idx;
        logic [PH_W-1:0]  phase;
    } seq_t;

    seq_t st_d, st_q;
    logic cap_now;
    logic next_empty;
    src_e cur_src;

    always_comb begin
        cur_src    = list_entry(32'(st_q.idx));
        next_empty = (list_entry(32'(st_q.idx) + 32'd1) == SRC_NONE);
        cap_now    = st_q.busy && (st_q.phase == '0);

        st_d      = st_q;
        st_d.done = 1'b0;

        if (st_q.busy) begin
            if (cap_now && next_empty) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.phase = '0;
            end else if (st_q.phase == PH_LAST) begin
                st_d.phase = '0;
                st_d.idx   = st_q.idx + 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
            if (rise_i) st_d.ovr = 1'b1;
        end else if (rise_i) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.phase = '0;
            st_d.ovr   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_en_o   = cap_now;
    assign cap_slot_o = st_q.idx[SLOT_W-1:0];
    assign cap_src_o  = cur_src;
    assign busy_o     = st_q.busy;
    assign done_o     = st_q.done;
    assign ovr_o      = st_q.ovr;

    // R2: an accepted edge starts capturing on the very next cycle
    p_start_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !busy_o) |=> (cap_en_o && cap_slot_o == '0));

    // R4: captures never sit on adjacent cycles when slots are wider than one
    p_slot_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_o && (SLOT_CYC > 1)) |=> !cap_en_o);

    // R5: completion strobe lasts one cycle and comes with busy low
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: an edge while busy raises the flag
    p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && busy_o) |=> ovr_o);

    // R7: no capture outside a run
    p_cap_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_o |-> busy_o);

endmodule

// File: rtl/pps_snap_store.sv
module pps_snap_store
    import pps_snap_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_en_i,
    input  logic [$clog2(N_CAPS)-1:0]    cap_slot_i,
    input  src_e                         cap_src_i,
    input  logic [DATA_W-1:0]            tmr_hi_i,
    input  logic [DATA_W-1:0]            tmr_lo_i,
    input  logic [DATA_W-1:0]            cnt_hi_i,
    input  logic [DATA_W-1:0]            cnt_lo_i,
    output logic [N_CAPS*DATA_W-1:0]     words_o
);
    logic [DATA_W-1:0] words_d [N_CAPS];
    logic [DATA_W-1:0] words_q [N_CAPS];
    logic [DATA_W-1:0] src_word;

    always_comb begin
        case (cap_src_i)
            SRC_TMR_HI: src_word = tmr_hi_i;
            SRC_TMR_LO: src_word = tmr_lo_i;
            SRC_CNT_HI: src_word = cnt_hi_i;
            SRC_CNT_LO: src_word = cnt_lo_i;
            default:    src_word = '0;
        endcase

        for (int i = 0; i < N_CAPS; i++) words_d[i] = words_q[i];
        if (cap_en_i) words_d[cap_slot_i] = src_word;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_CAPS; i++) begin
            if (!rst_n) words_q[i] <= '0;
            else        words_q[i] <= words_d[i];
        end
    end

    for (genvar g = 0; g < N_CAPS; g++) begin : g_flat
        assign words_o[g*DATA_W +: DATA_W] = words_q[g];
    end

    // R7: the buffer only moves on a capture
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> $stable(words_o));

endmodule

// File: rtl/pps_snap_merge.sv
module pps_snap_merge
    import pps_snap_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [N_CAPS*DATA_W-1:0] words_i,
    output logic [2*DATA_W-1:0]      stamp_o,
    output logic [2*DATA_W-1:0]      count_o
);
    logic [DATA_W-1:0] th1, tl1, th2, tl2;
    logic [DATA_W-1:0] ch1, cl1, ch2, cl2;

    assign th1 = words_i[SLOT_TH1*DATA_W +: DATA_W];
    assign tl1 = words_i[SLOT_TL1*DATA_W +: DATA_W];
    assign th2 = words_i[SLOT_TH2*DATA_W +: DATA_W];
    assign tl2 = words_i[SLOT_TL2*DATA_W +: DATA_W];
    assign ch1 = words_i[SLOT_CH1*DATA_W +: DATA_W];
    assign cl1 = words_i[SLOT_CL1*DATA_W +: DATA_W];
    assign ch2 = words_i[SLOT_CH2*DATA_W +: DATA_W];
    assign cl2 = words_i[SLOT_CL2*DATA_W +: DATA_W];

    always_comb begin
        // Timer: a changed upper word means the second pair is coherent
        if (th1 == th2) stamp_o = {th1, tl1};
        else            stamp_o = {th2, tl2};

        // Counter: keep the first lower read and pick the upper word that
        // was valid at that instant
        if (ch1 == ch2)      count_o = {ch1, cl1};
        else if (cl1 <= cl2) count_o = {ch2, cl1};
        else                 count_o = {ch1, cl1};
    end

endmodule

// File: rtl/pps_snapshot.sv
module pps_snapshot
    import pps_snap_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SLOT_CYC    = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pps_i,
    input  logic [DATA_W-1:0]        tmr_hi_i,
    input  logic [DATA_W-1:0]        tmr_lo_i,
    input  logic [DATA_W-1:0]        cnt_hi_i,
    input  logic [DATA_W-1:0]        cnt_lo_i,
    output logic [N_CAPS*DATA_W-1:0] words_o,
    output logic [2*DATA_W-1:0]      stamp_o,
    output logic [2*DATA_W-1:0]      count_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     overrun_o
);
    localparam int unsigned SLOT_W = $clog2(N_CAPS);

    logic              rise;
    logic              cap_en;
    logic [SLOT_W-1:0] cap_slot;
    src_e              cap_src;

    pps_snap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pps_i),
        .rise_o  (rise)
    );

    pps_snap_seq #(.SLOT_CYC(SLOT_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .cap_en_o   (cap_en),
        .cap_slot_o (cap_slot),
        .cap_src_o  (cap_src),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ovr_o      (overrun_o)
    );

    pps_snap_store #(.DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (cap_en),
        .cap_slot_i (cap_slot),
        .cap_src_i  (cap_src),
        .tmr_hi_i   (tmr_hi_i),
        .tmr_lo_i   (tmr_lo_i),
        .cnt_hi_i   (cnt_hi_i),
        .cnt_lo_i   (cnt_lo_i),
        .words_o    (words_o)
    );

    pps_snap_merge #(.DATA_W(DATA_W)) u_merge (
        .words_i (words_o),
        .stamp_o (stamp_o),
        .count_o (count_o)
    );

    // R6: the flag stays set while idle until a new run is accepted
    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !busy_o && !rise) |=> overrun_o);

endmodule

// File: tb/pps_snapshot_bench.sv
module pps_snapshot_bench;
    localparam int unsigned S  = 3;
    localparam int unsigned DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pps = 1'b0;
    bit [63:0] ecnt = 64'd0;
    bit [63:0] tbase = 64'd0;
    bit [63:0] cbase = 64'd0;
    logic [63:0] tmr_w, cnt_w;
    logic [8*DW-1:0] words;
    logic [63:0] stamp, count;
    logic busy, done, ovr;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;
    always_ff @(posedge clk) ecnt <= ecnt + 64'd1;

    assign tmr_w = tbase + ecnt;
    assign cnt_w = cbase + ecnt;

    pps_snapshot #(.DATA_W(DW), .SLOT_CYC(S), .SYNC_STAGES(2)) u_pps_snapshot (
        .clk       (clk),
        .rst_n     (rst_n),
        .pps_i     (pps),
        .tmr_hi_i  (tmr_w[63:32]),
        .tmr_lo_i  (tmr_w[31:0]),
        .cnt_hi_i  (cnt_w[63:32]),
        .cnt_lo_i  (cnt_w[31:0]),
        .words_o   (words),
        .stamp_o   (stamp),
        .count_o   (count),
        .busy_o    (busy),
        .done_o    (done),
        .overrun_o (ovr)
    );

    task automatic chk(input bit ok, input string req, input bit [255:0] act, input bit [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] word_of(input bit [255:0] w, input int k);
        return w[k*32 +: 32];
    endfunction

    // Ideal source value sampled at capture k of a run whose pulse rose after edge p
    function automatic bit [63:0] src_at(input bit [63:0] base, input bit [63:0] p, input int k);
        return base + p + 64'd3 + 64'(k * S);
    endfunction

    task automatic run_seq(input bit [63:0] tb, input bit [63:0] cb, input int hold_hi,
                           input bit inject, input int ovr_at, input string tag);
        bit [63:0] p, done_at;
        bit got;
        bit [255:0] exp_w;
        bit [63:0] t0, t1, t2, t3, c4, c5, c6, c7, exp_stamp;
        int extra;
        got = 1'b0;
        done_at = 64'd0;
        @(negedge clk);
        p = ecnt;
        tbase = tb;
        cbase = cb;
        pps = 1'b1;
        for (int c = 1; c <= 200; c++) begin
            @(negedge clk);
            if (c == hold_hi) pps = 1'b0;
            if (inject && c == ovr_at) pps = 1'b1;
            if (done) begin
                got = 1'b1;
                done_at = ecnt;
                break;
            end
        end
        t0 = src_at(tb, p, 0); t1 = src_at(tb, p, 1);
        t2 = src_at(tb, p, 2); t3 = src_at(tb, p, 3);
        c4 = src_at(cb, p, 4); c5 = src_at(cb, p, 5);
        c6 = src_at(cb, p, 6); c7 = src_at(cb, p, 7);
        exp_w = {c7[31:0], c6[63:32], c5[31:0], c4[63:32],
                 t3[31:0], t2[63:32], t1[31:0], t0[63:32]};
        chk(got && done_at == p + 64'd4 + 64'(7 * S), {"R5 done timing ", tag},
            256'(done_at), 256'(p + 64'd4 + 64'(7 * S)));
        chk(busy == 1'b0, {"R5 busy low at done ", tag}, 256'(busy), 256'd0);
        chk(word_of(words, 0) == word_of(exp_w, 0), {"R2 first capture ", tag},
            256'(word_of(words, 0)), 256'(word_of(exp_w, 0)));
        for (int k = 1; k < 8; k++)
            chk(word_of(words, k) == word_of(exp_w, k), {"R3 word order ", tag},
                256'(word_of(words, k)), 256'(word_of(exp_w, k)));
        exp_stamp = (t0[63:32] == t2[63:32]) ? t1 : t3;
        chk(stamp == exp_stamp, {"R8 merged timestamp ", tag}, 256'(stamp), 256'(exp_stamp));
        chk(count == c5, {"R9 merged count ", tag}, 256'(count), 256'(c5));
        chk(ovr == inject, {"R6 overrun flag ", tag}, 256'(ovr), 256'(inject));
        // Idle: buffer holds and no further strobe (R7, R10)
        extra = 0;
        for (int c = 0; c < 6 + int'($urandom % 8); c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        pps = 1'b0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, {"R10 single run per edge ", tag}, 256'(extra), 256'd0);
        chk(words == exp_w, {"R7 buffer held ", tag}, words, exp_w);
        chk(ovr == inject, {"R6 overrun sticky ", tag}, 256'(ovr), 256'(inject));
    endtask

    initial begin
        bit [31:0] seed_v;
        seed_v = $urandom(32'h51d3);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0 && ovr == 0, "R1 flags in reset", 256'({busy, done, ovr}), 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(words == '0, "R1 buffer zero", words, 256'd0);
        chk(stamp == 0 && count == 0, "R1 merged zero", 256'({stamp, count}), 256'd0);
        repeat (4) @(negedge clk);

        // R4: zero bases make the word5 - word1 spacing visible directly
        run_seq(64'd0, 64'd0, 3, 1'b0, 0, "zero");
        chk(word_of(words, 5) - word_of(words, 1) == 32'(4 * S), "R4 count instant spacing",
            256'(word_of(words, 5) - word_of(words, 1)), 256'(4 * S));
        chk(word_of(words, 3) - word_of(words, 1) == 32'(2 * S), "R4 slot spacing",
            256'(word_of(words, 3) - word_of(words, 1)), 256'(2 * S));

        // R8 corners: timer lower wraps between reads 0-1 and between reads 1-2
        run_seq(64'h0000_0005_FFFF_FFFF - (ecnt + 64'd4) - 64'd0, 64'h10, 2, 1'b0, 0, "tmr wrap a");
        run_seq(64'h0000_0009_FFFF_FFFF - (ecnt + 64'd4) - 64'(S), 64'h20, 2, 1'b0, 0, "tmr wrap b");
        // R9 corners: counter lower wraps just before and just after the word-5 read
        run_seq(64'h40, 64'h0000_0003_FFFF_FFFF - (ecnt + 64'd4) - 64'(4 * S) - 64'd1, 2, 1'b0, 0, "cnt wrap a");
        run_seq(64'h50, 64'h0000_0007_FFFF_FFFF - (ecnt + 64'd4) - 64'(5 * S), 2, 1'b0, 0, "cnt wrap b");

        // R6: second edge mid-run, then a clean run clears the flag
        run_seq(64'h1234_0000_0000, 64'h99, 3, 1'b1, 9, "overrun");
        run_seq(64'h77, 64'h88, 3, 1'b0, 0, "clear");

        // R10: level held well past the run
        run_seq(64'h1_0000_0000, 64'h2_0000_0000, 60, 1'b0, 0, "held");

        // Random runs, half of them with lower words near the wrap point
        for (int r = 0; r < 14; r++) begin
            bit [63:0] tb, cb;
            tb = {$urandom, $urandom};
            cb = {$urandom, $urandom};
            if ($urandom % 2 == 0) tb[31:0] = 32'hFFFF_FFD0 + ($urandom % 48);
            if ($urandom % 2 == 0) cb[31:0] = 32'hFFFF_FFD0 + ($urandom % 48);
            run_seq(tb, cb, 1 + int'($urandom % 40), 1'b0, 0, "random");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule